// File: doc/BRIEF.md
# Write Precompensation Delay Unit

This block sits in front of a floppy drive's write data output. It is clocked from a fixed 48 MHz reference. Each write data pulse leaves the block after a fixed nominal latency. If the pulse carries an early hint, it leaves sooner by a selectable amount. If it carries a late hint, it leaves later by that amount. The bit-pattern analysis that decides early or late is done upstream, and the hints arrive together with each pulse.

The amount of shift is a whole number of precompensation steps, chosen by a 3-bit code. The length of one step in reference ticks depends on whether the 2 Mbps rate is in force. Compensation applies only when the current track is at or above a configured start track. On lower tracks every pulse uses the nominal latency.

The block schedules the start and the end of each pulse separately, so the width of the output pulse matches the width of the input pulse.

Top module: `wprecomp_delay`

## Requirements
- R1: While `rst_n` is low, `wd_out` is 0. Any pulse that is scheduled but not yet sent is discarded.
- R2: The step count follows `pc_code`:
  - code 3'b111 selects 0 steps;
  - codes 3'b001 to 3'b110 select 1 to 6 steps, equal to the binary value of the code.
- R3: Code 3'b000 selects a default of 3 steps when `rate_2m` is 0, and 2 steps when `rate_2m` is 1.
- R4: One step is 2 ticks when `rate_2m` is 0, and 1 tick when it is 1. The nominal latency L is 6 steps. A rising `wd_in` first sampled high at clock edge n makes `wd_out` high from edge n+1+L.
- R5: With `late_hint`=1 and `early_hint`=0, the selected delay is added to L. With `early_hint`=1 and `late_hint`=0, it is subtracted from L. With both hints equal, L is used unchanged.
- R6: When `cur_track` < `start_track`, every pulse uses the nominal L whatever the hints and code. When `cur_track` equals `start_track`, the pulse is compensated.
- R7: The output pulse is high for exactly as many cycles as the input pulse was high. This holds for widths from 1 cycle upward.
- R8: The code, rate, track, start track and hints are sampled in the cycle of the rising edge. Changes to them while the pulse is high, including in the cycle where it falls, do not alter that pulse's timing or width.
- R9: Input pulses separated by at least 25 low cycles come out as separate pulses, in the same order, each with its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_code | input | 3 | Precompensation code |
| rate_2m | input | 1 | High when the 2 Mbps rate is in force |
| cur_track | input | TRK_W | Current track number |
| start_track | input | TRK_W | First track that is compensated |
| wd_in | input | 1 | Write data pulse input |
| early_hint | input | 1 | Move this pulse earlier |
| late_hint | input | 1 | Move this pulse later |
| wd_out | output | 1 | Compensated write data pulse |

## Verification
Two things can fall in the same cycle: the falling edge of a pulse that is being scheduled, and a change of the code, rate, track window and hints that would give a different latency. The bench provokes this by scrambling all settings in the cycle right after the rise. For a one-cycle pulse, that cycle is exactly the cycle of the fall. A behavioural model in the bench marks the expected output cycles from the settings held at the rise. The output is compared against that model on every clock, so a truncated, stretched or moved end of the pulse shows up as a miscompare. A late pulse with maximum delay, followed after the minimum gap by an early pulse with maximum delay, exercises the tightest case of two pulses in flight at once.

// File: rtl/wprecomp_delay.sv
module wprecomp_delay #(
  parameter int TRK_W      = 8,
  parameter int SLOW_TICKS = 2,
  parameter int FAST_TICKS = 1,
  parameter int BASE_STEPS = 6,
  parameter int DEF_SLOW   = 3,
  parameter int DEF_FAST   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       pc_code,
  input  logic             rate_2m,
  input  logic [TRK_W-1:0] cur_track,
  input  logic [TRK_W-1:0] start_track,
  input  logic             wd_in,
  input  logic             early_hint,
  input  logic             late_hint,
  output logic             wd_out
);
  localparam int LMAX = (BASE_STEPS + 6) * SLOW_TICKS;
  localparam int LW   = $clog2(LMAX + 1);

  logic          wd_q, rise, fall, comp_on;
  logic [2:0]    steps;
  logic [LW-1:0] tick, nominal, shift, lat, hold_lat;
  logic [LMAX:0] st_q, en_q, st_n, en_n;

  assign rise    = wd_in & ~wd_q;
  assign fall    = ~wd_in & wd_q;
  assign comp_on = cur_track >= start_track;

  assign steps = (pc_code == 3'b111) ? 3'd0 :
                 (pc_code == 3'b000) ? (rate_2m ? 3'(DEF_FAST) : 3'(DEF_SLOW)) :
                 pc_code;

  assign tick    = rate_2m ? LW'(FAST_TICKS) : LW'(SLOW_TICKS);
  assign nominal = LW'(BASE_STEPS) * tick;
  assign shift   = comp_on ? LW'(steps) * tick : '0;

  always_comb begin
    if (late_hint && !early_hint)
      lat = nominal + shift;
    else if (early_hint && !late_hint)
      lat = (shift > nominal) ? '0 : nominal - shift;
    else
      lat = nominal;
  end

  always_comb begin
    st_n = {1'b0, st_q[LMAX:1]};
    en_n = {1'b0, en_q[LMAX:1]};
    if (rise) st_n[lat] = 1'b1;
    if (fall) en_n[hold_lat] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q     <= 1'b0;
      hold_lat <= '0;
      st_q     <= '0;
      en_q     <= '0;
      wd_out   <= 1'b0;
    end else begin
      wd_q <= wd_in;
      st_q <= st_n;
      en_q <= en_n;
      if (rise) hold_lat <= lat;
      if (st_q[0])      wd_out <= 1'b1;
      else if (en_q[0]) wd_out <= 1'b0;
    end
  end

  a_r6_below_start_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cur_track < start_track) |=> hold_lat == $past(nominal));

  a_r5_late_not_sooner: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && late_hint && !early_hint) |=> hold_lat >= $past(nominal));

  a_r5_early_not_later: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && early_hint && !late_hint) |=> hold_lat <= $past(nominal));

  a_r8_latency_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q && wd_in) |=> $stable(hold_lat));

  a_r4_out_rise_scheduled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_out) |-> $past(st_q[0]));

  a_r7_out_fall_scheduled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_out) |-> $past(en_q[0]));
endmodule

// File: tb/wprecomp_delay_tb.sv
module wprecomp_delay_tb;
  localparam int CLK_PERIOD = 20;
  localparam int HORIZON    = 16384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pc_code = 3'b111;
  logic       rate_2m = 1'b0;
  logic [7:0] cur_track = 8'd0;
  logic [7:0] start_track = 8'd0;
  logic       wd_in = 1'b0;
  logic       early_hint = 1'b0;
  logic       late_hint = 1'b0;
  logic       wd_out;

  int    cyc = 0;
  int    nvec = 0;
  int    nerr = 0;
  bit    exp_q [HORIZON];
  string req = "R1";

  wprecomp_delay u_dut (
    .clk(clk), .rst_n(rst_n), .pc_code(pc_code), .rate_2m(rate_2m),
    .cur_track(cur_track), .start_track(start_track), .wd_in(wd_in),
    .early_hint(early_hint), .late_hint(late_hint), .wd_out(wd_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cyc < HORIZON) begin
      nvec++;
      if (wd_out !== exp_q[cyc]) begin
        nerr++;
        $display("FAIL %s cycle %0d: wd_out=%b expected %b", req, cyc, wd_out, exp_q[cyc]);
      end
    end
  end

  function automatic int model_lat(logic [2:0] code, logic fast, int trk, int stt,
                                   logic e, logic l);
    int st, t, nom;
    st  = (code == 3'b111) ? 0 : (code == 3'b000) ? (fast ? 2 : 3) : int'(code);
    t   = fast ? 1 : 2;
    nom = 6 * t;
    if (trk < stt || e == l) return nom;
    return l ? nom + st * t : nom - st * t;
  endfunction

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic send(string r, int w, int gap, logic [2:0] code, logic fast,
                      int trk, int stt, logic e, logic l, bit scramble);
    int s, lt;
    req = r;
    pc_code = code; rate_2m = fast; cur_track = 8'(trk); start_track = 8'(stt);
    early_hint = e; late_hint = l; wd_in = 1'b1;
    s  = cyc + 1;
    lt = model_lat(code, fast, trk, stt, e, l);
    for (int k = s + 1 + lt; k <= s + w + lt; k++) exp_q[k] = 1'b1;
    for (int i = 0; i < w; i++) begin
      step();
      if (i == 0 && scramble) begin
        pc_code = code ^ 3'b101; rate_2m = ~fast;
        early_hint = l; late_hint = e;
        cur_track = 8'd0; start_track = 8'd255;
      end
    end
    wd_in = 1'b0;
    early_hint = 1'b0; late_hint = 1'b0;
    repeat (gap) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (4) step();
    req = "R1";
    nvec++;
    if (wd_out !== 1'b0) begin
      nerr++;
      $display("FAIL R1 reset: wd_out=%b expected 0", wd_out);
    end
    rst_n = 1'b1;
    step();

    for (int c = 1; c < 8; c++) begin
      send("R2", 3, 30, 3'(c), 1'b0, 10, 0, 1'b0, 1'b1, 1'b0);
      send("R2", 3, 30, 3'(c), 1'b0, 10, 0, 1'b1, 1'b0, 1'b0);
      send("R2", 2, 30, 3'(c), 1'b1, 10, 0, 1'b0, 1'b1, 1'b0);
    end

    send("R3", 2, 30, 3'b000, 1'b0, 3, 0, 1'b0, 1'b1, 1'b0);
    send("R3", 2, 30, 3'b000, 1'b0, 3, 0, 1'b1, 1'b0, 1'b0);
    send("R3", 2, 30, 3'b000, 1'b1, 3, 0, 1'b0, 1'b1, 1'b0);
    send("R3", 2, 30, 3'b000, 1'b1, 3, 0, 1'b1, 1'b0, 1'b0);

    send("R4", 4, 30, 3'b110, 1'b0, 5, 0, 1'b0, 1'b0, 1'b0);
    send("R4", 4, 30, 3'b110, 1'b1, 5, 0, 1'b0, 1'b0, 1'b0);

    send("R5", 3, 30, 3'b101, 1'b0, 20, 0, 1'b1, 1'b1, 1'b0);
    send("R5", 3, 30, 3'b101, 1'b1, 20, 0, 1'b1, 1'b1, 1'b0);

    send("R6", 3, 30, 3'b110, 1'b0, 4, 5, 1'b0, 1'b1, 1'b0);
    send("R6", 3, 30, 3'b110, 1'b0, 4, 5, 1'b1, 1'b0, 1'b0);
    send("R6", 3, 30, 3'b110, 1'b0, 5, 5, 1'b0, 1'b1, 1'b0);
    send("R6", 3, 30, 3'b110, 1'b1, 5, 5, 1'b1, 1'b0, 1'b0);

    send("R7", 1, 30, 3'b011, 1'b0, 9, 2, 1'b0, 1'b1, 1'b0);
    send("R7", 2, 30, 3'b011, 1'b0, 9, 2, 1'b1, 1'b0, 1'b0);
    send("R7", 7, 30, 3'b100, 1'b1, 9, 2, 1'b0, 1'b1, 1'b0);
    send("R7", 15, 30, 3'b110, 1'b0, 9, 2, 1'b1, 1'b0, 1'b0);

    send("R8", 1, 30, 3'b110, 1'b0, 9, 0, 1'b0, 1'b1, 1'b1);
    send("R8", 1, 30, 3'b110, 1'b0, 9, 0, 1'b1, 1'b0, 1'b1);
    send("R8", 5, 30, 3'b010, 1'b1, 9, 0, 1'b0, 1'b1, 1'b1);
    send("R8", 5, 30, 3'b000, 1'b0, 9, 0, 1'b1, 1'b0, 1'b1);

    send("R9", 2, 25, 3'b110, 1'b0, 9, 0, 1'b0, 1'b1, 1'b0);
    send("R9", 2, 25, 3'b110, 1'b0, 9, 0, 1'b1, 1'b0, 1'b0);
    send("R9", 1, 25, 3'b110, 1'b0, 9, 0, 1'b0, 1'b1, 1'b0);
    send("R9", 1, 40, 3'b110, 1'b0, 9, 0, 1'b1, 1'b0, 1'b0);

    req = "R1";
    send("R1", 3, 14, 3'b110, 1'b0, 9, 0, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    for (int k = cyc; k < cyc + 40 && k < HORIZON; k++) exp_q[k] = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (35) step();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule